// File: doc/BRIEF.md
# Two-Key Matrix Keypad Scanner

The block scans a square switch matrix of normally open keys (8 column lines by 8 row lines by default, 64 keys). It pulls one column line low at a time and holds it there for a programmable number of clocks. Just before the column advances, it samples the row lines, which are pulled high externally and read active-low. A full pass over all columns produces a 64-bit image of the pressed keys. That image is debounced by requiring the same image on a programmable number of consecutive passes.

A stable image holding zero, one or two keys is decoded into two key-code slots, each with its own valid flag. A key code is `{column, row}`. A one-cycle key interrupt is raised whenever such a stable set differs from the previous stable set. A stable image that holds exactly the three configured reset-combination keys raises a separate one-cycle combination interrupt instead. Any other stable set of three or more keys leaves the slots untouched.

The row inputs pass through a two-flop synchronizer before they are sampled. The key-code slots and the interrupts are plain registered outputs with no handshake. No data stream enters or leaves the block, so there is no back-pressure to obey.

Top module: `kp_matrix_scanner`

## Requirements
- R1: After reset, column 0 is the only column driven low. The driven column advances 0,1,...,7 and then wraps to 0. Each column stays low for `scan_div`+1 clock cycles.
- R2: The key at column c, row r reads as pressed when column c is driven low and row r is seen low. Its code is c*8+r, that is `{c[2:0], r[2:0]}`.
- R3: When exactly one key is stably pressed, slot 0 is valid with its code, and slot 1 is invalid with code 0.
- R4: When exactly two keys are stably pressed, both slots are valid. Slot 0 holds the lower code and slot 1 the higher code.
- R5: A key image is accepted only after it is seen on `debounce_cnt` consecutive full scans, where a value of 0 counts as 1. A change that lasts fewer scans changes no output.
- R6: `key_irq` is a one-cycle pulse that fires when an accepted set of at most two keys differs from the previously accepted set. This includes the release of all keys, which clears both slots (both valid flags 0, both codes 0).
- R7: An accepted set of three or more keys that is not the reset combination leaves both slots unchanged and raises no interrupt.
- R8: An accepted set made of exactly the three distinct codes `combo_code_a`, `combo_code_b` and `combo_code_c`, in any order, raises a one-cycle `combo_irq`. It leaves the slots unchanged and does not raise `key_irq`.
- R9: During reset, both slots are invalid with code 0, both interrupts are low, and `col_drive_n` is 8'hFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_div | input | 16 | Clocks per column minus one; at least 2 |
| debounce_cnt | input | 8 | Matching scans needed to accept an image (0 acts as 1) |
| combo_code_a | input | 6 | First key code of the reset combination |
| combo_code_b | input | 6 | Second key code of the reset combination |
| combo_code_c | input | 6 | Third key code of the reset combination |
| row_sense_n | input | 8 | Row lines, active-low |
| col_drive_n | output | 8 | Column lines, one low at a time |
| key0_valid | output | 1 | Slot 0 holds a key |
| key0_code | output | 6 | Slot 0 key code (the lower code) |
| key1_valid | output | 1 | Slot 1 holds a key |
| key1_code | output | 6 | Slot 1 key code (the higher code) |
| key_irq | output | 1 | Pulse: new accepted set of at most two keys |
| combo_irq | output | 1 | Pulse: reset combination accepted |

## Verification
The assertions assume the following about the inputs:
- `scan_div` is at least 2, so that the synchronized row lines reflect the driven column before they are sampled.
- The configuration inputs stay constant while keys are changing.
- The three combination codes are distinct.

The bench models the matrix combinationally from a pressed-key vector, runs with `scan_div` of 3, and changes `debounce_cnt` only while the matrix is idle and the last event has been accepted. Glitches are kept to a single column-7 sample, so they can never reach the debounce count.

// File: rtl/kp_pkg.sv
package kp_pkg;
  typedef enum logic [1:0] {
    SET_NONE  = 2'd0,
    SET_KEYS  = 2'd1,
    SET_COMBO = 2'd2,
    SET_MANY  = 2'd3
  } set_kind_e;
endpackage

// File: rtl/kp_col_scan.sv
module kp_col_scan #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     scan_div,
  input  logic [ROWS-1:0]      row_sense_n,
  output logic [COLS-1:0]      col_drive_n,
  output logic [ROWS*COLS-1:0] frame_img,
  output logic                 frame_stb
);
  localparam int CIDX_W = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int NKEYS  = ROWS * COLS;

  logic [DIV_W-1:0]  div_q;
  logic [CIDX_W-1:0] col_q;
  logic [ROWS-1:0]   row_s1, row_s2;
  logic [NKEYS-1:0]  acc_q, acc_next;
  logic              tick, last_col;

  assign tick     = (div_q == scan_div);
  assign last_col = (col_q == CIDX_W'(COLS - 1));

  always_comb begin
    acc_next = acc_q;
    acc_next[col_q*ROWS +: ROWS] = ~row_s2;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_drive_n[c] = (col_q != CIDX_W'(c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      col_q     <= '0;
      row_s1    <= '1;
      row_s2    <= '1;
      acc_q     <= '0;
      frame_img <= '0;
      frame_stb <= 1'b0;
    end else begin
      row_s1    <= row_sense_n;
      row_s2    <= row_s1;
      frame_stb <= 1'b0;
      if (tick) begin
        div_q <= '0;
        acc_q <= acc_next;
        if (last_col) begin
          col_q     <= '0;
          frame_img <= acc_next;
          frame_stb <= 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R1: a column change is always a step to the next column
  a_r1_col_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (col_drive_n != $past(col_drive_n)) |->
      (col_drive_n == {$past(col_drive_n[COLS-2:0]), $past(col_drive_n[COLS-1])}));

  // R1: exactly one column low
  a_r1_one_col: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~col_drive_n) == 1);
endmodule

// File: rtl/kp_set_decode.sv
module kp_set_decode #(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int CODE_W = 6
) (
  input  logic [ROWS*COLS-1:0] img,
  input  logic [CODE_W-1:0]    combo_a,
  input  logic [CODE_W-1:0]    combo_b,
  input  logic [CODE_W-1:0]    combo_c,
  output kp_pkg::set_kind_e    kind,
  output logic [1:0]           n_keys,
  output logic [CODE_W-1:0]    lo_code,
  output logic [CODE_W-1:0]    hi_code
);
  import kp_pkg::*;
  localparam int NKEYS = ROWS * COLS;

  logic [NKEYS-1:0] combo_mask;
  logic [1:0]       cnt;

  always_comb begin
    cnt     = 2'd0;
    lo_code = '0;
    hi_code = '0;
    for (int i = 0; i < NKEYS; i++) begin
      combo_mask[i] = (CODE_W'(i) == combo_a) || (CODE_W'(i) == combo_b) ||
                      (CODE_W'(i) == combo_c);
      if (img[i]) begin
        if (cnt == 2'd0)      lo_code = CODE_W'(i);
        else if (cnt == 2'd1) hi_code = CODE_W'(i);
        if (cnt != 2'd3) cnt = cnt + 2'd1;
      end
    end
  end

  assign n_keys = cnt;

  always_comb begin
    if (cnt == 2'd0)                        kind = SET_NONE;
    else if (cnt != 2'd3)                   kind = SET_KEYS;
    else if (img == combo_mask)             kind = SET_COMBO;
    else                                    kind = SET_MANY;
  end
endmodule

// File: rtl/kp_debounce_report.sv
module kp_debounce_report #(
  parameter int NKEYS  = 64,
  parameter int CODE_W = 6,
  parameter int DEB_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEB_W-1:0]   debounce_cnt,
  input  logic               frame_stb,
  input  logic [NKEYS-1:0]   frame_img,
  input  kp_pkg::set_kind_e  kind,
  input  logic [1:0]         n_keys,
  input  logic [CODE_W-1:0]  lo_code,
  input  logic [CODE_W-1:0]  hi_code,
  output logic               key0_valid,
  output logic [CODE_W-1:0]  key0_code,
  output logic               key1_valid,
  output logic [CODE_W-1:0]  key1_code,
  output logic               key_irq,
  output logic               combo_irq
);
  import kp_pkg::*;

  logic [NKEYS-1:0] prev_img, commit_img;
  logic [DEB_W-1:0] run_q, run_next, thr;
  logic             accept;

  assign thr = (debounce_cnt == '0) ? DEB_W'(1) : debounce_cnt;

  always_comb begin
    if (frame_img != prev_img)  run_next = DEB_W'(1);
    else if (run_q == '1)       run_next = run_q;
    else                        run_next = run_q + 1'b1;
  end

  assign accept = frame_stb && (run_next == thr) && (frame_img != commit_img);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_img   <= '0;
      commit_img <= '0;
      run_q      <= '0;
      key0_valid <= 1'b0;
      key0_code  <= '0;
      key1_valid <= 1'b0;
      key1_code  <= '0;
      key_irq    <= 1'b0;
      combo_irq  <= 1'b0;
    end else begin
      key_irq   <= 1'b0;
      combo_irq <= 1'b0;
      if (frame_stb) begin
        prev_img <= frame_img;
        run_q    <= run_next;
      end
      if (accept) begin
        commit_img <= frame_img;
        case (kind)
          SET_NONE, SET_KEYS: begin
            key0_valid <= (n_keys != 2'd0);
            key0_code  <= lo_code;
            key1_valid <= (n_keys == 2'd2);
            key1_code  <= (n_keys == 2'd2) ? hi_code : '0;
            key_irq    <= 1'b1;
          end
          SET_COMBO: combo_irq <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  a_r6_key_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    key_irq |=> !key_irq);

  a_r8_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_irq && combo_irq));

  a_r4_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
    key1_valid |-> (key0_valid && (key0_code < key1_code)));

  a_r8_combo_holds: assert property (@(posedge clk) disable iff (!rst_n)
    combo_irq |-> ($stable(key0_valid) && $stable(key0_code) &&
                   $stable(key1_valid) && $stable(key1_code)));

  a_r5_irq_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (key_irq || combo_irq) |-> $past(frame_stb));
endmodule

// File: rtl/kp_matrix_scanner.sv
module kp_matrix_scanner #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int DIV_W = 16,
  parameter int DEB_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [DIV_W-1:0]                 scan_div,
  input  logic [DEB_W-1:0]                 debounce_cnt,
  input  logic [$clog2(ROWS*COLS)-1:0]     combo_code_a,
  input  logic [$clog2(ROWS*COLS)-1:0]     combo_code_b,
  input  logic [$clog2(ROWS*COLS)-1:0]     combo_code_c,
  input  logic [ROWS-1:0]                  row_sense_n,
  output logic [COLS-1:0]                  col_drive_n,
  output logic                             key0_valid,
  output logic [$clog2(ROWS*COLS)-1:0]     key0_code,
  output logic                             key1_valid,
  output logic [$clog2(ROWS*COLS)-1:0]     key1_code,
  output logic                             key_irq,
  output logic                             combo_irq
);
  localparam int NKEYS  = ROWS * COLS;
  localparam int CODE_W = $clog2(NKEYS);

  logic [NKEYS-1:0]   frame_img;
  logic               frame_stb;
  kp_pkg::set_kind_e  kind;
  logic [1:0]         n_keys;
  logic [CODE_W-1:0]  lo_code, hi_code;

  kp_col_scan #(.ROWS(ROWS), .COLS(COLS), .DIV_W(DIV_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .scan_div(scan_div), .row_sense_n(row_sense_n),
    .col_drive_n(col_drive_n), .frame_img(frame_img), .frame_stb(frame_stb));

  kp_set_decode #(.ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W)) u_dec (
    .img(frame_img), .combo_a(combo_code_a), .combo_b(combo_code_b),
    .combo_c(combo_code_c), .kind(kind), .n_keys(n_keys),
    .lo_code(lo_code), .hi_code(hi_code));

  kp_debounce_report #(.NKEYS(NKEYS), .CODE_W(CODE_W), .DEB_W(DEB_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .debounce_cnt(debounce_cnt),
    .frame_stb(frame_stb), .frame_img(frame_img), .kind(kind), .n_keys(n_keys),
    .lo_code(lo_code), .hi_code(hi_code),
    .key0_valid(key0_valid), .key0_code(key0_code),
    .key1_valid(key1_valid), .key1_code(key1_code),
    .key_irq(key_irq), .combo_irq(combo_irq));
endmodule

// File: tb/kp_matrix_scanner_test.sv
`timescale 1ns/1ps
module kp_matrix_scanner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] scan_div = 16'd3;
  logic [7:0]  debounce_cnt = 8'd3;
  logic [5:0]  combo_code_a = 6'd5, combo_code_b = 6'd18, combo_code_c = 6'd60;
  logic [7:0]  row_sense_n, col_drive_n;
  logic        key0_valid, key1_valid, key_irq, combo_irq;
  logic [5:0]  key0_code, key1_code;
  logic [63:0] pressed = '0;
  int          n_checks = 0, n_fail = 0;
  bit          done = 1'b0;

  typedef struct packed {
    logic       combo;
    logic       v0;
    logic [5:0] c0;
    logic       v1;
    logic [5:0] c1;
  } ev_t;
  ev_t   expq[$];
  string tagq[$];

  always #2 clk = ~clk;

  kp_matrix_scanner uut (
    .clk(clk), .rst_n(rst_n), .scan_div(scan_div), .debounce_cnt(debounce_cnt),
    .combo_code_a(combo_code_a), .combo_code_b(combo_code_b),
    .combo_code_c(combo_code_c), .row_sense_n(row_sense_n),
    .col_drive_n(col_drive_n), .key0_valid(key0_valid), .key0_code(key0_code),
    .key1_valid(key1_valid), .key1_code(key1_code),
    .key_irq(key_irq), .combo_irq(combo_irq));

  // matrix model: R2 code = col*8 + row
  always_comb begin
    for (int r = 0; r < 8; r++) begin
      row_sense_n[r] = 1'b1;
      for (int c = 0; c < 8; c++)
        if (!col_drive_n[c] && pressed[c*8 + r]) row_sense_n[r] = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic expect_ev(input logic combo, input logic v0, input logic [5:0] c0,
                           input logic v1, input logic [5:0] c1, input string tag);
    expq.push_back('{combo, v0, c0, v1, c1});
    tagq.push_back(tag);
  endtask

  task automatic settle();
    repeat (400) @(posedge clk);
  endtask

  task automatic chk_slots(input logic v0, input logic [5:0] c0, input logic v1,
                           input logic [5:0] c1, input string tag);
    @(negedge clk);
    chk({key0_valid, key0_code, key1_valid, key1_code} == {v0, c0, v1, c1}, tag,
        32'({key0_valid, key0_code, key1_valid, key1_code}), 32'({v0, c0, v1, c1}));
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (key_irq || combo_irq)) begin
      ev_t got;
      got = '{combo_irq, key0_valid, key0_code, key1_valid, key1_code};
      if (expq.size() == 0) begin
        chk(1'b0, "R5/R7 unexpected interrupt", 32'(got), 32'h0);
      end else begin
        ev_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(got == e, t, 32'(got), 32'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    int cyc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(col_drive_n == 8'hFE, "R9 col during reset", 32'(col_drive_n), 32'hFE);
    chk({key0_valid, key1_valid, key_irq, combo_irq} == 4'b0, "R9 outputs during reset",
        32'({key0_valid, key1_valid, key_irq, combo_irq}), 0);
    rst_n = 1'b1;

    // R1 column order and period
    prev = col_drive_n;
    while (col_drive_n == prev) @(negedge clk);
    for (int i = 1; i <= 8; i++) begin
      prev = col_drive_n;
      cyc = 0;
      while (col_drive_n == prev) begin
        @(negedge clk);
        cyc++;
      end
      chk(col_drive_n == ~(8'd1 << ((i + 1) % 8)), "R1 column order",
          32'(col_drive_n), 32'(~(8'd1 << ((i + 1) % 8))));
      chk(cyc == 4, "R1 column period", cyc, 4);
    end
    settle();

    // R2/R3 single key col2 row5 = 21
    pressed[21] = 1'b1;
    expect_ev(0, 1, 6'd21, 0, 6'd0, "R3 single key");
    settle();
    chk_slots(1, 6'd21, 0, 6'd0, "R2 code of col2 row5");

    // R4 second key code 1: lower goes to slot 0
    pressed[1] = 1'b1;
    expect_ev(0, 1, 6'd1, 1, 6'd21, "R4 two keys ordered");
    settle();

    // R5 glitch shorter than debounce
    pressed[63] = 1'b1;
    repeat (10) @(posedge clk);
    pressed[63] = 1'b0;
    settle();
    chk_slots(1, 6'd1, 1, 6'd21, "R5 glitch ignored");

    // R7 third non-combo key
    pressed[40] = 1'b1;
    settle();
    chk_slots(1, 6'd1, 1, 6'd21, "R7 three keys hold slots");
    pressed[40] = 1'b0;
    expect_ev(0, 1, 6'd1, 1, 6'd21, "R6 return from three keys");
    settle();

    // R6 release all
    pressed = '0;
    expect_ev(0, 0, 6'd0, 0, 6'd0, "R6 release clears slots");
    settle();

    // R8 reset combination
    pressed[5] = 1'b1; pressed[18] = 1'b1; pressed[60] = 1'b1;
    expect_ev(1, 0, 6'd0, 0, 6'd0, "R8 combination");
    settle();
    chk_slots(0, 6'd0, 0, 6'd0, "R8 slots held");
    pressed = '0;
    expect_ev(0, 0, 6'd0, 0, 6'd0, "R6 release after combination");
    settle();

    // R5 debounce of 0 acts as 1
    debounce_cnt = 8'd0;
    pressed[7] = 1'b1;
    expect_ev(0, 1, 6'd7, 0, 6'd0, "R5 debounce zero");
    settle();
    pressed = '0;
    expect_ev(0, 0, 6'd0, 0, 6'd0, "R6 release debounce zero");
    settle();
    debounce_cnt = 8'd3;
    settle();

    // R5 latency and R4 code extremes 0 and 63
    pressed[0] = 1'b1; pressed[63] = 1'b1;
    repeat (60) @(posedge clk);
    chk_slots(0, 6'd0, 0, 6'd0, "R5 not accepted before debounce count");
    expect_ev(0, 1, 6'd0, 1, 6'd63, "R4 extreme codes");
    settle();

    chk(expq.size() == 0, "R6 missing events", expq.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule